// File: doc/BRIEF.md
# Indirect Pointer Address and Update Unit

This unit serves a processor datapath that reaches memory through a register used as a pointer. Each request gives the number of the pointer register (one of eight), that register's current contents, and whether the access reads or writes memory. The unit returns the memory address to use. It also returns the value to write back into the pointer register, a write-enable for that write-back, a memory-access enable and an illegal-operand flag.

The update rule depends on which register is the pointer:

- **Register 0** cannot act as a pointer. The unit refuses it.
- **Registers 1 to 3** are plain pointers and are left unchanged.
- **Registers 4, 5 and 7** step forward by one after each use. Register 7 is the program counter, so inline constants can be fetched through it.
- **Register 6** works as a stack pointer. A read steps it back by one first and uses the lowered value as the address. A write uses the current value as the address and steps it forward afterwards.

All pointer arithmetic is modulo 2^16. The result is registered one cycle after a request strobe and is qualified by an output-valid signal. The decoder and the register file around the unit consume that result.

Top module: `ptr_step_unit`

## Requirements
- R1: A request presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high. A cycle with `in_valid` low gives `out_valid`, `out_ptr_we` and `out_mem_en` all low on the next clock.
- R2: After reset, `out_valid`, `out_ptr_we`, `out_mem_en` and `out_illegal` are all low.
- R3: When register number 0 is selected, `out_illegal` is high and both `out_mem_en` and `out_ptr_we` are low, for either direction.
- R4: When register 1, 2 or 3 is selected:
  - `out_addr` equals the input value.
  - `out_ptr_we` is low.
  - `out_ptr_new` equals the input value.
  - `out_mem_en` is high.
- R5: When register 4 or 5 is selected, for reads (`in_write`=0) and writes (`in_write`=1) alike:
  - `out_addr` equals the input value.
  - `out_ptr_new` equals the input value plus one.
  - `out_ptr_we` is high.
- R6: Register 7 behaves exactly as registers 4 and 5 do: the address is the current value and the new value is the current value plus one, with write-back enabled.
- R7: A read through register 6 gives `out_addr` = `out_ptr_new` = input value minus one, with `out_ptr_we` high.
- R8: A write through register 6 gives `out_addr` equal to the input value and `out_ptr_new` equal to the input value plus one, with `out_ptr_we` high.
- R9: Pointer arithmetic wraps modulo 2^16: 0xFFFF plus one gives 0x0000, and 0x0000 minus one gives 0xFFFF.
- R10: A write through register 6 followed by a read through register 6 that starts from the write's updated value gives:
  - the same memory address on both accesses;
  - the register's original value as the read's updated value.
- R11: `out_reg` repeats the selected register number, so the write-back target is known.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_reg | input | 3 | Pointer register number |
| in_val | input | 16 | Current contents of the pointer register |
| in_write | input | 1 | 1 = memory write, 0 = memory read |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_reg | output | 3 | Register number for write-back |
| out_addr | output | 16 | Effective memory address |
| out_ptr_new | output | 16 | Updated pointer value |
| out_ptr_we | output | 1 | Pointer write-back enable |
| out_mem_en | output | 1 | Memory access enable |
| out_illegal | output | 1 | Register 0 was selected as a pointer |

## Verification
The assertions take for granted that `in_reg`, `in_val` and `in_write` are stable and meaningful in any cycle where `in_valid` is high. They make no assumption about these inputs otherwise. The stimulus drives every input only on the falling clock edge, so each request is settled well before the rising edge that captures it. The stimulus also places idle cycles between requests, and these cycles still satisfy the assertions.

// File: rtl/ptr_pkg.sv
package ptr_pkg;

    typedef enum logic [1:0] {
        PM_ILLEGAL = 2'd0,
        PM_PLAIN   = 2'd1,
        PM_POSTINC = 2'd2,
        PM_STACK   = 2'd3
    } ptr_mode_e;

endpackage

// File: rtl/ptr_class.sv
module ptr_class
    import ptr_pkg::*;
#(
    parameter int REG_W       = 3,
    parameter int ILLEGAL_REG = 0,
    parameter int STACK_REG   = 6,
    parameter int PC_REG      = 7,
    parameter int INC_LO      = 4,
    parameter int INC_HI      = 5
) (
    input  logic [REG_W-1:0] reg_sel,
    output ptr_mode_e        mode
);
    localparam int NUM_REGS = 1 << REG_W;

    ptr_mode_e mode_tab [NUM_REGS];

    // One table entry per register number, chosen at elaboration time.
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_tab
        if (i == ILLEGAL_REG) begin : g_ill
            assign mode_tab[i] = PM_ILLEGAL;
        end else if (i == STACK_REG) begin : g_stk
            assign mode_tab[i] = PM_STACK;
        end else if (i == PC_REG || (i >= INC_LO && i <= INC_HI)) begin : g_inc
            assign mode_tab[i] = PM_POSTINC;
        end else begin : g_pln
            assign mode_tab[i] = PM_PLAIN;
        end
    end

    assign mode = mode_tab[reg_sel];

endmodule

// File: rtl/ptr_arith.sv
module ptr_arith
    import ptr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  ptr_mode_e          mode,
    input  logic               is_write,
    input  logic [ADDR_W-1:0]  cur,
    output logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  nxt,
    output logic               we,
    output logic               access,
    output logic               illegal
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] inc_v;
    logic [ADDR_W-1:0] dec_v;

    always_comb begin
        inc_v   = cur + ONE;
        dec_v   = cur - ONE;
        addr    = cur;
        nxt     = cur;
        we      = 1'b0;
        access  = 1'b1;
        illegal = 1'b0;
        case (mode)
            PM_ILLEGAL: begin
                access  = 1'b0;
                illegal = 1'b1;
            end
            PM_PLAIN: begin
                addr = cur;
            end
            PM_POSTINC: begin
                nxt = inc_v;
                we  = 1'b1;
            end
            PM_STACK: begin
                we = 1'b1;
                if (is_write) begin
                    nxt = inc_v;
                end else begin
                    addr = dec_v;
                    nxt  = dec_v;
                end
            end
            default: begin
                access  = 1'b0;
                illegal = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ptr_step_unit.sv
module ptr_step_unit
    import ptr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int REG_W     = 3,
    parameter int STACK_REG = 6,
    parameter int PC_REG    = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [REG_W-1:0]  in_reg,
    input  logic [ADDR_W-1:0] in_val,
    input  logic              in_write,
    output logic              out_valid,
    output logic [REG_W-1:0]  out_reg,
    output logic [ADDR_W-1:0] out_addr,
    output logic [ADDR_W-1:0] out_ptr_new,
    output logic              out_ptr_we,
    output logic              out_mem_en,
    output logic              out_illegal
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    typedef struct packed {
        logic              valid;
        logic [REG_W-1:0]  rsel;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] nxt;
        logic              we;
        logic              access;
        logic              illegal;
    } res_t;

    ptr_mode_e         mode_w;
    logic [ADDR_W-1:0] addr_w;
    logic [ADDR_W-1:0] nxt_w;
    logic              we_w;
    logic              acc_w;
    logic              ill_w;
    res_t              res_d;
    res_t              res_q;

    ptr_class #(
        .REG_W       (REG_W),
        .ILLEGAL_REG (0),
        .STACK_REG   (STACK_REG),
        .PC_REG      (PC_REG),
        .INC_LO      (4),
        .INC_HI      (5)
    ) u_class (
        .reg_sel (in_reg),
        .mode    (mode_w)
    );

    ptr_arith #(
        .ADDR_W (ADDR_W)
    ) u_arith (
        .mode     (mode_w),
        .is_write (in_write),
        .cur      (in_val),
        .addr     (addr_w),
        .nxt      (nxt_w),
        .we       (we_w),
        .access   (acc_w),
        .illegal  (ill_w)
    );

    always_comb begin
        res_d         = res_q;
        res_d.valid   = in_valid;
        res_d.we      = 1'b0;
        res_d.access  = 1'b0;
        res_d.illegal = 1'b0;
        if (in_valid) begin
            res_d.rsel    = in_reg;
            res_d.addr    = addr_w;
            res_d.nxt     = nxt_w;
            res_d.we      = we_w;
            res_d.access  = acc_w;
            res_d.illegal = ill_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid   = res_q.valid;
    assign out_reg     = res_q.rsel;
    assign out_addr    = res_q.addr;
    assign out_ptr_new = res_q.nxt;
    assign out_ptr_we  = res_q.we;
    assign out_mem_en  = res_q.access;
    assign out_illegal = res_q.illegal;

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_ptr_we && !out_mem_en));

    assert_reject_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_reg == '0) |=> (out_illegal && !out_ptr_we && !out_mem_en));

    assert_plain_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_reg >= REG_W'(1) && in_reg <= REG_W'(3))
        |=> (!out_ptr_we && out_addr == $past(in_val)));

    assert_postinc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_reg == REG_W'(4) || in_reg == REG_W'(5) || in_reg == REG_W'(PC_REG)))
        |=> (out_ptr_we && out_ptr_new == $past(in_val) + ONE));

    assert_stack_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_reg == REG_W'(STACK_REG) && !in_write)
        |=> (out_addr == out_ptr_new && out_ptr_new == $past(in_val) - ONE));

    assert_stack_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_reg == REG_W'(STACK_REG) && in_write)
        |=> (out_addr == $past(in_val) && out_ptr_new == $past(in_val) + ONE));

    assert_echo_reg_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_reg == $past(in_reg));

endmodule

// File: tb/ptr_step_unit_test.sv
`timescale 1ns/1ps
module ptr_step_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  in_reg = '0;
    logic [15:0] in_val = '0;
    logic        in_write = 1'b0;
    logic        out_valid;
    logic [2:0]  out_reg;
    logic [15:0] out_addr;
    logic [15:0] out_ptr_new;
    logic        out_ptr_we;
    logic        out_mem_en;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ptr_step_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_reg(in_reg),
        .in_val(in_val), .in_write(in_write), .out_valid(out_valid),
        .out_reg(out_reg), .out_addr(out_addr), .out_ptr_new(out_ptr_new),
        .out_ptr_we(out_ptr_we), .out_mem_en(out_mem_en), .out_illegal(out_illegal)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] r, input logic [15:0] v, input logic w);
        @(negedge clk);
        in_valid = 1'b1; in_reg = r; in_val = v; in_write = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_of(input logic [2:0] r, input logic [15:0] v, input logic w,
                             output logic [15:0] ea, output logic [15:0] en,
                             output logic ewe, output logic eme, output logic eil);
        ea = v; en = v; ewe = 1'b0; eme = 1'b1; eil = 1'b0;
        if (r == 3'd0) begin
            eme = 1'b0; eil = 1'b1;
        end else if (r == 3'd6) begin
            ewe = 1'b1;
            if (w) en = v + 16'd1;
            else begin ea = v - 16'd1; en = v - 16'd1; end
        end else if (r >= 3'd4) begin
            ewe = 1'b1; en = v + 16'd1;
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] vals [6];
        logic [15:0] ea, en;
        logic ewe, eme, eil;
        logic [15:0] push_addr, sp1;
        string tag;
        vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF;
        vals[3] = 16'h8000; vals[4] = 16'hFFFF; vals[5] = 16'h1234;

        repeat (3) @(negedge clk);
        chk("R2 valid", out_valid, 0);
        chk("R2 we", out_ptr_we, 0);
        chk("R2 mem_en", out_mem_en, 0);
        chk("R2 illegal", out_illegal, 0);
        rst_n = 1'b1;

        for (int r = 0; r < 8; r++) begin
            for (int w = 0; w < 2; w++) begin
                for (int k = 0; k < 6; k++) begin
                    expect_of(3'(r), vals[k], 1'(w), ea, en, ewe, eme, eil);
                    if (r == 0) tag = "R3";
                    else if (r < 4) tag = "R4";
                    else if (r == 7) tag = "R6";
                    else if (r == 6) tag = (w == 1) ? "R8" : "R7";
                    else tag = "R5";
                    if (vals[k] == 16'hFFFF || vals[k] == 16'h0000) tag = {tag, "/R9"};
                    issue(3'(r), vals[k], 1'(w));
                    chk({"R1 valid ", tag}, out_valid, 1);
                    chk({"R11 reg ", tag}, out_reg, 32'(r));
                    chk({tag, " illegal"}, out_illegal, eil);
                    chk({tag, " mem_en"}, out_mem_en, eme);
                    chk({tag, " we"}, out_ptr_we, ewe);
                    if (r != 0) begin
                        chk({tag, " addr"}, out_addr, ea);
                        chk({tag, " new"}, out_ptr_new, en);
                    end
                    @(negedge clk);
                    chk("R1 idle valid", out_valid, 0);
                    chk("R1 idle we", out_ptr_we, 0);
                    chk("R1 idle mem_en", out_mem_en, 0);
                end
            end
        end

        // R9 explicit wrap points
        issue(3'd4, 16'hFFFF, 1'b0);
        chk("R9 inc wrap", out_ptr_new, 16'h0000);
        issue(3'd6, 16'h0000, 1'b0);
        chk("R9 dec wrap", out_ptr_new, 16'hFFFF);

        // R10 push then pull
        for (int k = 0; k < 6; k++) begin
            issue(3'd6, vals[k], 1'b1);
            push_addr = out_addr;
            sp1 = out_ptr_new;
            issue(3'd6, sp1, 1'b0);
            chk("R10 same addr", out_addr, push_addr);
            chk("R10 sp restored", out_ptr_new, vals[k]);
        end

        // R1 back-to-back requests
        @(negedge clk);
        in_valid = 1'b1; in_reg = 3'd5; in_val = 16'h0010; in_write = 1'b0;
        @(negedge clk);
        chk("R1 b2b first", out_ptr_new, 16'h0011);
        in_reg = 3'd6; in_val = 16'h0020; in_write = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 b2b second", out_addr, 16'h001F);
        chk("R1 b2b valid", out_valid, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule